// File: doc/BRIEF.md
# Serial Receive Overrun and Holding Control

This block sits between the word assembler of a serial receiver and the registers that software reads. Each time the assembler signals that a full word is ready, the block decides whether the word can enter the holding stage. In single-register mode the holding stage keeps one word. In queued mode it is a first-in first-out buffer of eight words. If the holding stage has no room, the word is dropped and a sticky overrun flag is raised. The words already held are left as they were.

The overrun flag never requests an interrupt by itself. It only changes which receive vector accompanies a request that the data path raises: a plain data vector or a data-with-exception vector. Software clears the flag with a status read that observes it set, followed by a data read. Any other register access between those two reads cancels the clear. A low module enable clears the flag and empties the holding stage. The receiver enable gates new words but leaves the flag alone. An occupancy count lets software judge how much data was really lost.

Top module: `rx_overrun_ctrl`

## Requirements
- R1: With `mod_en` and `rx_en` high, a `word_done` pulse with room in the holding stage stores `word_in`. `rd_data` presents the oldest stored word, and a `data_rd` pulse removes it, so words leave in arrival order.
- R2: The holding stage holds 8 words when `fifo_en`=1 and 1 word when `fifo_en`=0. `rx_ready` is 1 whenever at least one word is held, and `fifo_full` is 1 when 8 words are held.
- R3: A `word_done` pulse while the holding stage is full sets `ovr_flag` on the next cycle. The new word is discarded, and both the held words and `fifo_level` stay unchanged.
- R4: `ovr_flag` never raises `rx_irq` on its own: with the flag set and the level below the request threshold, `rx_irq` stays 0.
- R5: In queued mode `rx_irq` is 1 when `fifo_level` is at least 1 and at least `wmark`. In single mode it follows `rx_ready`. `irq_vec` is 2'b00 with no request, 2'b01 with a request and the flag clear, and 2'b10 with a request and the flag set.
- R6: `mod_en` low clears `ovr_flag`, empties the holding stage and cancels a pending clear sequence, all visible one cycle later.
- R7: A `stat_rd` pulse while `ovr_flag` is 1, followed by a `data_rd` pulse, clears `ovr_flag` one cycle after the data read. A `data_rd` without that preceding status read leaves the flag set.
- R8: An `other_acc` pulse between the status read and the data read cancels the clear, and the flag stays set.
- R9: A `stat_rd` that sees `ovr_flag` at 0 does not arm the clear, even if an overrun occurs before the next data read.
- R10: With `rx_en` low, `word_done` pulses are ignored (level and contents are unchanged), and `ovr_flag` keeps its value.
- R11: `fifo_level` reports the number of held words, from 0 to 8, and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low clears the block's state |
| rx_en | input | 1 | Receiver enable; gates new words |
| fifo_en | input | 1 | 1 selects the 8-word queue, 0 selects the single register |
| wmark | input | 4 | Queue level at which a receive request is raised |
| word_done | input | 1 | One-cycle pulse: a complete word is in the shift stage |
| word_in | input | 16 | Word from the shift stage |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Receive data register read strobe |
| other_acc | input | 1 | Strobe for any other register access |
| rd_data | output | 16 | Oldest held word |
| rx_ready | output | 1 | At least one word is held |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_level | output | 4 | Number of held words |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| irq_vec | output | 2 | Vector select: 00 none, 01 data, 10 data with exception |

## Verification
The bound assertions check on every cycle that an overrun sets the flag without moving the level, that a low module enable clears everything, that the flag stays set until a data read, that the level stays within the capacity of the selected mode, and that the vector code matches the request and the flag. Some behaviour depends on an ordered series of accesses and only the bench's scenarios can show it. This covers the two-read clear sequence, its cancellation by an intervening access or by a status read that saw the flag clear, the arrival order of words through all eight entries, and the fact that a dropped word never shows up on the read path.

// File: rtl/rx_ovr_pkg.sv
package rx_ovr_pkg;
  typedef enum logic [1:0] {
    VEC_NONE = 2'b00,
    VEC_DATA = 2'b01,
    VEC_EXC  = 2'b10
  } rx_vec_e;

  function automatic logic [1:0] vec_code(input logic req, input logic exc);
    rx_vec_e v;
    if (!req)     v = VEC_NONE;
    else if (exc) v = VEC_EXC;
    else          v = VEC_DATA;
    return v;
  endfunction
endpackage

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] level_q, level_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // next state
  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    level_n  = level_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      level_n  = '0;
    end else begin
      if (push) wr_ptr_n = bump(wr_ptr_q);
      if (pop)  rd_ptr_n = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   level_n = level_q + 1'b1;
        2'b01:   level_n = level_q - 1'b1;
        default: level_n = level_q;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      level_q  <= level_n;
    end
  end

  // storage, write-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign level = level_q;
endmodule

// File: rtl/rx_ovr_flag.sv
module rx_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic ovr_evt,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic other_acc,
  output logic flag
);
  logic flag_q, flag_n;
  logic armed_q, armed_n;
  logic clr;

  // next state
  always_comb begin
    clr     = data_rd && armed_q;
    armed_n = armed_q;
    flag_n  = flag_q;
    if (!mod_en) begin
      armed_n = 1'b0;
      flag_n  = 1'b0;
    end else begin
      if (stat_rd)                   armed_n = flag_q;
      else if (other_acc || data_rd) armed_n = 1'b0;
      flag_n = ovr_evt || (flag_q && !clr);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      armed_q <= armed_n;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/rx_irq_sel.sv
module rx_irq_sel #(
  parameter int CW = 4
) (
  input  logic          fifo_en,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] wmark,
  input  logic          ovr,
  output logic          irq,
  output logic [1:0]    vec
);
  import rx_ovr_pkg::*;
  logic held;

  always_comb begin
    held = (level != '0);
    if (fifo_en) irq = held && (level >= wmark);
    else         irq = held;
    vec = vec_code(irq, ovr);
  end
endmodule

// File: rtl/rx_overrun_ctrl.sv
module rx_overrun_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic          rx_en,
  input  logic          fifo_en,
  input  logic [CW-1:0] wmark,
  input  logic          word_done,
  input  logic [DW-1:0] word_in,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          other_acc,
  output logic [DW-1:0] rd_data,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic [CW-1:0] fifo_level,
  output logic          ovr_flag,
  output logic          rx_irq,
  output logic [1:0]    irq_vec
);
  logic [CW-1:0] level;
  logic          stage_full;
  logic          accept;
  logic          push;
  logic          pop;
  logic          ovr_evt;

  always_comb begin
    rx_ready   = (level != '0);
    fifo_full  = (level == CW'(DEPTH));
    stage_full = fifo_en ? fifo_full : rx_ready;
    accept     = word_done && rx_en && mod_en;
    push       = accept && !stage_full;
    ovr_evt    = accept && stage_full;
    pop        = data_rd && rx_ready && mod_en;
  end

  rx_hold_fifo #(.DW(DW), .DEPTH(DEPTH)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!mod_en),
    .push  (push),
    .pop   (pop),
    .din   (word_in),
    .dout  (rd_data),
    .level (level)
  );

  rx_ovr_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .ovr_evt   (ovr_evt),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .other_acc (other_acc),
    .flag      (ovr_flag)
  );

  rx_irq_sel #(.CW(CW)) u_irq (
    .fifo_en (fifo_en),
    .level   (level),
    .wmark   (wmark),
    .ovr     (ovr_flag),
    .irq     (rx_irq),
    .vec     (irq_vec)
  );

  assign fifo_level = level;
endmodule

// File: rtl/rx_overrun_chk.sv
module rx_overrun_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_en,
  input logic          rx_en,
  input logic          fifo_en,
  input logic          word_done,
  input logic          data_rd,
  input logic          rx_ready,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_level,
  input logic          ovr_flag,
  input logic          rx_irq,
  input logic [1:0]    irq_vec
);
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && rx_en && word_done && !data_rd && (fifo_en ? fifo_full : rx_ready))
    |=> (ovr_flag && fifo_level == $past(fifo_level)));

  p_mod_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!ovr_flag && fifo_level == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && ovr_flag && !data_rd) ##1 mod_en |-> ovr_flag);

  p_rx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !rx_en && !data_rd) ##1 mod_en |-> $stable(fifo_level));

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= CW'(DEPTH)) && (fifo_en || fifo_level <= 1));

  p_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq ? (irq_vec == (ovr_flag ? 2'b10 : 2'b01)) : (irq_vec == 2'b00));
endmodule

bind rx_overrun_ctrl rx_overrun_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_en     (mod_en),
  .rx_en      (rx_en),
  .fifo_en    (fifo_en),
  .word_done  (word_done),
  .data_rd    (data_rd),
  .rx_ready   (rx_ready),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .ovr_flag   (ovr_flag),
  .rx_irq     (rx_irq),
  .irq_vec    (irq_vec)
);

// File: tb/sim_rx_overrun_ctrl.sv
module sim_rx_overrun_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0, rx_en = 1'b0, fifo_en = 1'b0;
  logic [3:0]  wmark = 4'd1;
  logic        word_done = 1'b0;
  logic [15:0] word_in = '0;
  logic        stat_rd = 1'b0, data_rd = 1'b0, other_acc = 1'b0;
  logic [15:0] rd_data;
  logic        rx_ready, fifo_full, ovr_flag, rx_irq;
  logic [3:0]  fifo_level;
  logic [1:0]  irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  rx_overrun_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .rx_en(rx_en), .fifo_en(fifo_en),
    .wmark(wmark), .word_done(word_done), .word_in(word_in), .stat_rd(stat_rd),
    .data_rd(data_rd), .other_acc(other_acc), .rd_data(rd_data), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .ovr_flag(ovr_flag),
    .rx_irq(rx_irq), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (data_rd && mod_en && exp_q.size() > 0) begin
      chk("R1 read order", int'(rd_data), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
  end

  task automatic cyc(input logic wd, input logic [15:0] w,
                     input logic sr, input logic dr, input logic oa);
    @(posedge clk); #1;
    word_done = wd; word_in = w; stat_rd = sr; data_rd = dr; other_acc = oa;
    @(posedge clk); #1;
    word_done = 1'b0; stat_rd = 1'b0; data_rd = 1'b0; other_acc = 1'b0;
  endtask

  // driver: predicts whether the word is kept
  task automatic push_word(input logic [15:0] w);
    int cap;
    cap = fifo_en ? 8 : 1;
    if (mod_en && rx_en && exp_q.size() < cap) exp_q.push_back(w);
    cyc(1'b1, w, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_data_t;  cyc(1'b0, '0, 1'b0, 1'b1, 1'b0); endtask
  task automatic rd_stat;    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0); endtask
  task automatic acc_other;  cyc(1'b0, '0, 1'b0, 1'b0, 1'b1); endtask

  task automatic set_mod(input logic v);
    @(posedge clk); #1; mod_en = v;
    if (!v) exp_q.delete();
    @(posedge clk); #1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 reset level", fifo_level, 0);
    chk("R6 reset flag", ovr_flag, 0);
    chk("R5 reset vec", irq_vec, 0);

    // single-register mode
    mod_en = 1'b1; rx_en = 1'b1; fifo_en = 1'b0;
    push_word(16'hA001);
    chk("R2 rx_ready", rx_ready, 1);
    chk("R5 plain vec", irq_vec, 2'b01);
    push_word(16'hA002);
    chk("R3 overrun flag", ovr_flag, 1);
    chk("R3 level held", fifo_level, 1);
    chk("R5 exc vec", irq_vec, 2'b10);
    rd_data_t();
    chk("R7 no clear without status", ovr_flag, 1);
    chk("R4 no irq from flag", rx_irq, 0);
    rd_stat();
    rd_data_t();
    chk("R7 cleared by sequence", ovr_flag, 0);

    // cancelled sequence
    push_word(16'hA003);
    push_word(16'hA004);
    rd_stat();
    acc_other();
    rd_data_t();
    chk("R8 cancelled clear", ovr_flag, 1);
    rd_stat();
    rd_data_t();
    chk("R7 second clear", ovr_flag, 0);

    // status read with flag clear does not arm
    rd_stat();
    push_word(16'hA005);
    push_word(16'hA006);
    rd_data_t();
    chk("R9 not armed", ovr_flag, 1);

    // receiver disabled
    rx_en = 1'b0;
    push_word(16'hA007);
    chk("R10 word ignored", fifo_level, 0);
    chk("R10 flag kept", ovr_flag, 1);
    rx_en = 1'b1;

    // module disable clears state, including an armed sequence
    push_word(16'hA008);
    rd_stat();
    set_mod(1'b0);
    set_mod(1'b1);
    chk("R6 flag cleared", ovr_flag, 0);
    chk("R6 stage emptied", fifo_level, 0);
    push_word(16'hA009);
    push_word(16'hA00A);
    rd_data_t();
    chk("R6 sequence cancelled", ovr_flag, 1);
    set_mod(1'b0);
    set_mod(1'b1);

    // queued mode
    fifo_en = 1'b1; wmark = 4'd4;
    for (int i = 0; i < 3; i++) push_word(16'hB000 + 16'(i));
    chk("R11 level 3", fifo_level, 3);
    chk("R5 below mark", rx_irq, 0);
    push_word(16'hB003);
    chk("R5 at mark", irq_vec, 2'b01);
    for (int i = 4; i < 8; i++) push_word(16'hB000 + 16'(i));
    chk("R2 full", fifo_full, 1);
    chk("R3 no flag at full", ovr_flag, 0);
    push_word(16'hBEEF);
    chk("R3 queue overrun", ovr_flag, 1);
    chk("R3 queue level held", fifo_level, 8);
    chk("R5 exc vec queued", irq_vec, 2'b10);
    for (int i = 0; i < 5; i++) rd_data_t();
    chk("R11 level after reads", fifo_level, 3);
    chk("R4 flag without irq", rx_irq, 0);
    chk("R4 vec none", irq_vec, 2'b00);
    for (int i = 0; i < 3; i++) rd_data_t();
    chk("R1 drained", fifo_level, 0);
    chk("R1 scoreboard empty", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule